// File: doc/BRIEF.md
# Parallel Flash Command State Machine

This block is the device-side command interpreter of a byte-wide NOR-style memory. A host issues bus write cycles (address, data and a one-cycle write strobe). The block recognises keyed multi-write sequences that do four things: return to array reads, enter an identification mode, program one byte, or erase the whole array. A small internal byte array stands in for the real cells.

Program and erase run as timed internal operations. While one runs, reads return status bits and every bus write is ignored. When it ends, the block goes back to plain array reads. Program can only clear bits. Erase first drives every unprotected byte to zero and then sets it to all ones. Sectors marked in a protection parameter are never changed.

The key writes are AAh at address 555h and then 55h at address 2AAh, compared on the low 11 address bits. Commands are written to address 555h: A0h program, 80h erase set-up, 10h chip erase, 90h identification. F0h written to any address forces array reads.

Top module: `nor_cmd_fsm`

## Requirements
- R1: After reset, reads return array contents, `busy` is 0 and every byte reads FFh.
- R2: The four writes AA@555, 55@2AA, A0@555 and then data D at address X start a program. Once it ends, byte X holds its old value ANDed with D.
- R3: A program that asks for any 0-to-1 change leaves those bits at 0. While that program is busy, read bit 5 is 1; for any other program it is 0.
- R4: The six writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 start a chip erase. Once it ends, every unprotected byte reads FFh.
- R5: After AA@555, 55@2AA, 90@555, reads depend on the low address byte. 00h returns the manufacturer code (3Dh by default) and 01h the device code (B7h by default). 02h returns 01h if the sector in the address is protected and 00h if not. Sector = address bits [9:8] with the defaults.
- R6: Identification mode persists over any number of reads. Other low address bytes read 00h. Only a write of F0h leaves the mode, and after that array data is read again.
- R7: Bus writes made while `busy` is 1 have no effect on mode or on the array.
- R8: While busy, read bit 7 is the complement of the data's bit 7 for a program and 0 for an erase. Bit 6 inverts on every read strobe. Bits 4..0 are 0.
- R9: `busy` stays high for PROG_CYC cycles (default 8) after a program starts and ERASE_CYC cycles (default 40) after an erase starts. When it falls, reads return array data again.
- R10: A write that does not match the next expected key returns the block to array reads. A later command byte written without fresh keys has no effect.
- R11: Program or erase aimed at a protected sector (default: sector 2, addresses 200h–2FFh) leaves its bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | One-cycle write strobe |
| bus_re | input | 1 | One-cycle read strobe; advances the status toggle bit |
| bus_rdata | output | 8 | Array byte, identification code or status |
| busy | output | 1 | Internal program or erase in progress |

## Verification
The assertions assume that a read strobe and a write strobe are never high in the same cycle. They also assume that each strobe lasts exactly one cycle, with address and data held steady while it is high. The toggle property depends on that, because a strobe held high for two cycles would flip bit 6 twice. The bench drives every transfer at the falling edge, raises one strobe for a single clock, then lowers it before the next transfer. Its writes during busy periods are complete command sequences, so they exercise the ignore rule without breaking the single-strobe assumption.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam int BUS_AW = 12;
    localparam int KEY_AW = 11;

    localparam logic [KEY_AW-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [KEY_AW-1:0] KEY_ADDR_B = 11'h2AA;
    localparam logic [7:0] KEY_DATA_A = 8'hAA;
    localparam logic [7:0] KEY_DATA_B = 8'h55;
    localparam logic [7:0] OPC_PROG   = 8'hA0;
    localparam logic [7:0] OPC_ESETUP = 8'h80;
    localparam logic [7:0] OPC_CHIP   = 8'h10;
    localparam logic [7:0] OPC_IDENT  = 8'h90;
    localparam logic [7:0] OPC_RESET  = 8'hF0;

    typedef enum logic [2:0] {
        MD_READ, MD_KEY1, MD_KEY2, MD_PSET,
        MD_EKEY0, MD_EKEY1, MD_EKEY2, MD_IDENT
    } cmd_mode_e;

    typedef struct packed {
        logic              is_erase;
        logic              bad_bit;
        logic [BUS_AW-1:0] addr;
        logic [7:0]        data;
    } op_ctx_t;

    function automatic logic hit(input logic [BUS_AW-1:0] a, input logic [7:0] d,
                                 input logic [KEY_AW-1:0] ka, input logic [7:0] kd);
        return (a[KEY_AW-1:0] == ka) && (d == kd);
    endfunction

endpackage

// File: rtl/nor_seq_decode.sv
module nor_seq_decode
    import nor_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              busy,
    input  logic [BUS_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output cmd_mode_e         mode,
    output logic              start_prog,
    output logic              start_erase
);
    cmd_mode_e mode_nx;

    always_comb begin
        mode_nx     = mode;
        start_prog  = 1'b0;
        start_erase = 1'b0;
        if (we && !busy) begin
            unique case (mode)
                MD_READ:  mode_nx = hit(addr, wdata, KEY_ADDR_A, KEY_DATA_A) ? MD_KEY1 : MD_READ;
                MD_KEY1:  mode_nx = hit(addr, wdata, KEY_ADDR_B, KEY_DATA_B) ? MD_KEY2 : MD_READ;
                MD_KEY2: begin
                    if (hit(addr, wdata, KEY_ADDR_A, OPC_PROG))        mode_nx = MD_PSET;
                    else if (hit(addr, wdata, KEY_ADDR_A, OPC_ESETUP)) mode_nx = MD_EKEY0;
                    else if (hit(addr, wdata, KEY_ADDR_A, OPC_IDENT))  mode_nx = MD_IDENT;
                    else                                               mode_nx = MD_READ;
                end
                MD_PSET: begin
                    start_prog = 1'b1;
                    mode_nx    = MD_READ;
                end
                MD_EKEY0: mode_nx = hit(addr, wdata, KEY_ADDR_A, KEY_DATA_A) ? MD_EKEY1 : MD_READ;
                MD_EKEY1: mode_nx = hit(addr, wdata, KEY_ADDR_B, KEY_DATA_B) ? MD_EKEY2 : MD_READ;
                MD_EKEY2: begin
                    start_erase = hit(addr, wdata, KEY_ADDR_A, OPC_CHIP);
                    mode_nx     = MD_READ;
                end
                MD_IDENT: mode_nx = MD_IDENT;
                default:  mode_nx = MD_READ;
            endcase
            if (wdata == OPC_RESET && mode != MD_PSET)
                mode_nx = MD_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MD_READ;
        else     mode <= mode_nx;
    end
endmodule

// File: rtl/nor_op_timer.sv
module nor_op_timer #(
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start_prog,
    input  logic start_erase,
    output logic busy,
    output logic mid_pulse,
    output logic done_pulse
);
    localparam int CNT_W = $clog2(ERASE_CYC + 1);
    localparam logic [CNT_W-1:0] MID_AT = CNT_W'(ERASE_CYC / 2);

    logic [CNT_W-1:0] cnt;
    logic             erasing;

    assign done_pulse = busy && (cnt == CNT_W'(1));
    assign mid_pulse  = busy && erasing && (cnt == MID_AT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            busy    <= 1'b0;
            erasing <= 1'b0;
        end else if (!busy && (start_prog || start_erase)) begin
            cnt     <= start_erase ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
            busy    <= 1'b1;
            erasing <= start_erase;
        end else if (busy) begin
            cnt <= cnt - CNT_W'(1);
            if (done_pulse) begin
                busy    <= 1'b0;
                erasing <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nor_byte_array.sv
module nor_byte_array #(
    parameter int                  MEM_BYTES = 1024,
    parameter int                  NUM_SECT  = 4,
    parameter logic [NUM_SECT-1:0] PROTECT   = 4'b0100,
    localparam int                 ADDR_W    = $clog2(MEM_BYTES),
    localparam int                 SECT_W    = $clog2(NUM_SECT),
    localparam int                 SECT_B    = MEM_BYTES / NUM_SECT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pgm_en,
    input  logic [ADDR_W-1:0] pgm_idx,
    input  logic [7:0]        pgm_mask,
    input  logic              fill_zero,
    input  logic              fill_one,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [7:0]        rd_byte
);
    logic [7:0]          cells [MEM_BYTES];
    logic [NUM_SECT-1:0] sect_open;

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        assign sect_open[s] = !PROTECT[s];
    end

    assign rd_byte = cells[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) cells[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                if (sect_open[i / SECT_B]) begin
                    if (fill_zero)     cells[i] <= 8'h00;
                    else if (fill_one) cells[i] <= 8'hFF;
                end
            end
            if (pgm_en && sect_open[pgm_idx[ADDR_W-1 -: SECT_W]])
                cells[pgm_idx] <= cells[pgm_idx] & pgm_mask;
        end
    end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_cmd_pkg::*;
#(
    parameter int                  MEM_BYTES = 1024,
    parameter int                  NUM_SECT  = 4,
    parameter logic [NUM_SECT-1:0] PROTECT   = 4'b0100,
    parameter int                  PROG_CYC  = 8,
    parameter int                  ERASE_CYC = 40,
    parameter logic [7:0]          MFR_CODE  = 8'h3D,
    parameter logic [7:0]          DEV_CODE  = 8'hB7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_we,
    input  logic        bus_re,
    output logic [7:0]  bus_rdata,
    output logic        busy
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int SECT_W = $clog2(NUM_SECT);

    cmd_mode_e   mode;
    logic        start_prog, start_erase, mid_pulse, done_pulse;
    logic        toggle_q, op_is_erase;
    logic [7:0]  arr_byte, ident_byte;
    op_ctx_t     ctx;

    nor_seq_decode u_dec (
        .clk(clk), .rst(rst), .we(bus_we), .busy(busy),
        .addr(bus_addr), .wdata(bus_wdata), .mode(mode),
        .start_prog(start_prog), .start_erase(start_erase)
    );

    nor_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
        .clk(clk), .rst(rst), .start_prog(start_prog), .start_erase(start_erase),
        .busy(busy), .mid_pulse(mid_pulse), .done_pulse(done_pulse)
    );

    nor_byte_array #(.MEM_BYTES(MEM_BYTES), .NUM_SECT(NUM_SECT), .PROTECT(PROTECT)) u_arr (
        .clk(clk), .rst(rst),
        .pgm_en(done_pulse && !ctx.is_erase),
        .pgm_idx(ctx.addr[ADDR_W-1:0]),
        .pgm_mask(ctx.data),
        .fill_zero(mid_pulse),
        .fill_one(done_pulse && ctx.is_erase),
        .rd_idx(bus_addr[ADDR_W-1:0]),
        .rd_byte(arr_byte)
    );

    assign op_is_erase = ctx.is_erase;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx      <= '0;
            toggle_q <= 1'b0;
        end else begin
            if (start_prog && !busy) begin
                ctx.is_erase <= 1'b0;
                ctx.bad_bit  <= |(bus_wdata & ~arr_byte);
                ctx.addr     <= bus_addr;
                ctx.data     <= bus_wdata;
            end else if (start_erase && !busy) begin
                ctx          <= '0;
                ctx.is_erase <= 1'b1;
            end else if (done_pulse) begin
                ctx <= '0;
            end
            if (busy && bus_re) toggle_q <= !toggle_q;
        end
    end

    always_comb begin
        unique case (bus_addr[7:0])
            8'h00:   ident_byte = MFR_CODE;
            8'h01:   ident_byte = DEV_CODE;
            8'h02:   ident_byte = {7'd0, PROTECT[bus_addr[ADDR_W-1 -: SECT_W]]};
            default: ident_byte = 8'h00;
        endcase
    end

    always_comb begin
        if (busy)
            bus_rdata = {ctx.is_erase ? 1'b0 : !ctx.data[7], toggle_q, ctx.bad_bit, 5'd0};
        else if (mode == MD_IDENT)
            bus_rdata = ident_byte;
        else
            bus_rdata = arr_byte;
    end
endmodule

// File: rtl/nor_cmd_fsm_chk.sv
module nor_cmd_fsm_chk
    import nor_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       re,
    input logic       busy,
    input logic [7:0] rdata,
    input cmd_mode_e  mode,
    input logic       start_prog,
    input logic       start_erase,
    input logic       op_erase
);
    AST_BUSY_HOLDS_MODE: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode)); // R7

    AST_END_IN_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (mode == MD_READ)); // R9

    AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (busy && re) |=> (!busy || (rdata[6] != $past(rdata[6])))); // R8

    AST_ERASE_DQ7_LOW: assert property (@(posedge clk) disable iff (rst)
        (busy && op_erase) |-> !rdata[7]); // R8

    AST_IDENT_NO_START: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_IDENT) |-> !(start_prog || start_erase)); // R6

    AST_SINGLE_START: assert property (@(posedge clk) disable iff (rst)
        !(start_prog && start_erase)); // R2

    AST_STATUS_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rdata[4:0] == 5'd0)); // R8
endmodule

bind nor_cmd_fsm nor_cmd_fsm_chk u_chk (
    .clk(clk), .rst(rst), .re(bus_re), .busy(busy), .rdata(bus_rdata),
    .mode(mode), .start_prog(start_prog), .start_erase(start_erase),
    .op_erase(op_is_erase)
);

// File: tb/nor_cmd_fsm_tb.sv
module nor_cmd_fsm_tb;
    localparam int         PROG_CYC  = 8;
    localparam int         ERASE_CYC = 40;
    localparam logic [7:0] MFR       = 8'h3D;
    localparam logic [7:0] DEV       = 8'hB7;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WT = 2'd2;
    localparam int NV = 41;
    // op[25:24] addr[23:12] data[11:4] req[3:0]
    localparam logic [25:0] VEC [NV] = '{
        {OP_RD, 12'h010, 8'hFF, 4'd1},   // R1 erased at start
        {OP_WR, 12'h555, 8'hAA, 4'd2},   // R2 program 5A at 010
        {OP_WR, 12'h2AA, 8'h55, 4'd2},
        {OP_WR, 12'h555, 8'hA0, 4'd2},
        {OP_WR, 12'h010, 8'h5A, 4'd2},
        {OP_WT, 12'h000, 8'd12, 4'd2},
        {OP_RD, 12'h010, 8'h5A, 4'd2},
        {OP_WR, 12'h555, 8'hAA, 4'd3},   // R3 program A5 over 5A -> 00
        {OP_WR, 12'h2AA, 8'h55, 4'd3},
        {OP_WR, 12'h555, 8'hA0, 4'd3},
        {OP_WR, 12'h010, 8'hA5, 4'd3},
        {OP_WT, 12'h000, 8'd12, 4'd3},
        {OP_RD, 12'h010, 8'h00, 4'd3},
        {OP_WR, 12'h555, 8'hAA, 4'd10},  // R10 broken sequence
        {OP_WR, 12'h123, 8'h00, 4'd10},
        {OP_WR, 12'h555, 8'hA0, 4'd10},
        {OP_WR, 12'h020, 8'h00, 4'd10},
        {OP_WT, 12'h000, 8'd12, 4'd10},
        {OP_RD, 12'h020, 8'hFF, 4'd10},
        {OP_WR, 12'h555, 8'hAA, 4'd5},   // R5 identification
        {OP_WR, 12'h2AA, 8'h55, 4'd5},
        {OP_WR, 12'h555, 8'h90, 4'd5},
        {OP_RD, 12'h000, MFR,   4'd5},
        {OP_RD, 12'h001, DEV,   4'd5},
        {OP_RD, 12'h202, 8'h01, 4'd5},
        {OP_RD, 12'h102, 8'h00, 4'd5},
        {OP_RD, 12'h310, 8'h00, 4'd6},   // R6 other offsets, persistence
        {OP_RD, 12'h100, MFR,   4'd6},
        {OP_WR, 12'h000, 8'hF0, 4'd6},
        {OP_RD, 12'h010, 8'h00, 4'd6},
        {OP_WR, 12'h555, 8'hAA, 4'd11},  // R11 protected program
        {OP_WR, 12'h2AA, 8'h55, 4'd11},
        {OP_WR, 12'h555, 8'hA0, 4'd11},
        {OP_WR, 12'h210, 8'h00, 4'd11},
        {OP_WT, 12'h000, 8'd12, 4'd11},
        {OP_RD, 12'h210, 8'hFF, 4'd11},
        {OP_WR, 12'h555, 8'hAA, 4'd4},   // R4 chip erase (first key)
        {OP_WR, 12'h2AA, 8'h55, 4'd4},
        {OP_WR, 12'h555, 8'h80, 4'd4},
        {OP_WR, 12'h555, 8'hAA, 4'd4},
        {OP_WR, 12'h2AA, 8'h55, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        busy;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #5ns clk = !clk;

    nor_cmd_fsm #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
                  .MFR_CODE(MFR), .DEV_CODE(DEV)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1ns v = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic prog_seq(input logic [11:0] a, input logic [7:0] d);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(a, d);
    endtask

    initial begin
        logic [7:0] s0, s1;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 busy after reset", int'(busy), 0);

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            case (v[25:24])
                OP_WR: wr(v[23:12], v[11:4]);
                OP_RD: begin
                    rd(v[23:12], s0);
                    check($sformatf("R%0d read %0h", v[3:0], v[23:12]), int'(s0), int'(v[11:4]));
                end
                default: repeat (int'(v[11:4])) @(negedge clk);
            endcase
        end
        // R4 last erase write, R9 erase duration, R8 erase status, R7 ignored writes
        wr(12'h555, 8'h10);
        n = 0;
        rd(12'h000, s0);
        check("R8 erase DQ7", int'(s0[7]), 0);
        n = n + 2;
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
        n = n + 6;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        check("R9 erase busy cycles", n, ERASE_CYC);
        rd(12'h000, s0);
        check("R7 writes during busy ignored", int'(s0), 8'hFF);
        rd(12'h010, s0);
        check("R4 erased byte", int'(s0), 8'hFF);
        rd(12'h3FF, s0);
        check("R4 last byte erased", int'(s0), 8'hFF);
        rd(12'h210, s0);
        check("R11 protected after erase", int'(s0), 8'hFF);

        // R8 program status and toggle, R9 program duration
        prog_seq(12'h030, 8'h00);
        n = 0;
        rd(12'h030, s0);
        rd(12'h030, s1);
        n = 4;
        check("R8 program DQ7", int'(s0[7]), 1);
        check("R8 DQ6 toggles", int'(s1[6]), int'(!s0[6]));
        check("R8 low bits zero", int'(s0[4:0]), 0);
        check("R3 DQ5 clear on legal program", int'(s0[5]), 0);
        while (busy && n < 1000) begin n++; @(negedge clk); end
        check("R9 program busy cycles", n, PROG_CYC);
        rd(12'h030, s0);
        check("R9 array read after program", int'(s0), 0);

        // R3 0-to-1 request flags DQ5
        prog_seq(12'h030, 8'h01);
        rd(12'h030, s0);
        check("R3 DQ5 set on 0-to-1", int'(s0[5]), 1);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(12'h030, s0);
        check("R3 cell stays 0", int'(s0), 0);

        // R1 reset from identification mode with programmed data
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        check("R1 busy low", int'(busy), 0);
        rd(12'h000, s0);
        check("R1 array mode after reset", int'(s0), 8'hFF);
        rd(12'h030, s0);
        check("R1 array erased after reset", int'(s0), 8'hFF);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule